// File: doc/BRIEF.md
# Stack Syllable Execution Unit

This unit runs a program one syllable at a time against an operand stack of 32-bit words held in a local register file. A sequencer offers one 6-bit syllable per handshake, or a full 32-bit word to push. The unit does logic and add operations, a signed-direction shift, exchange, and copy and overwrite at a distance below the top. It also does jumps and a branch that tests a popped word for zero, sets the negative and zero status flags, and issues single-word loads and stores on a request/acknowledge memory port. Jumps and taken branches come back to the sequencer as a one-cycle redirect carrying the new PC.

Control is a three-state machine. `ST_RUN` accepts syllables (`syl_ready` high). A load or store moves it to `ST_MEMWAIT`, where the request is held until `mem_ack` returns it to `ST_RUN`. The halt syllable or a stack fault moves it to `ST_HALT`, which only reset leaves. Every other syllable completes in the cycle it is accepted, and the machine stays in `ST_RUN`. The atomic compare-and-exchange and context-switch encodings are flagged as unsupported and otherwise act as no-ops.

Top module: `stk_syl_exec`

## Requirements
- R1: After reset `depth` is 0, `psw_flags` is 0, `syl_ready` is 1, and `halted`, `fault`, `unsup`, `mem_req` and `redir_valid` are all 0.
- R2: Code `1xxxxx` pushes its low 5 bits zero-extended to 32 bits. With `syl_wide` high, the unit pushes `syl_word` and ignores the code. Either push raises `depth` by one.
- R3: Code `011xxx` pushes a copy of the entry x places below the top, where x = code[2:0] and x = 0 is the top itself.
- R4: Code `010xxx` pops the top, then writes that value over the entry x places below the new top.
- R5: Codes `001000` (AND), `001001` (OR), `001011` (XOR) and `001100` (ADD, modulo 2^32) pop two entries and push the result. Code `001010` replaces the top with its bitwise inverse.
- R6: Code `001101` exchanges the top two entries.
- R7: Code `000100` pops an amount (top), then a value. A non-negative amount shifts the value left. A negative amount shifts it right logically by the magnitude. A magnitude of 32 or more gives 0. The result is pushed.
- R8: Code `001110` pops the top. In the following cycle `redir_valid` is high for one cycle and `redir_pc` equals the popped value.
- R9: Code `000111` pops a target (top), then a test word. It redirects to the target only when the test word is zero, and pops both either way.
- R10: Code `000110` pops the top and sets `psw_flags[1]` to its bit 31 and `psw_flags[0]` to (value == 0). No other syllable changes the flags.
- R11: Code `000010` pops an address and pushes the word read there. Code `000011` pops an address, then data, and writes the data there. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay steady until `mem_ack`, and no syllable is accepted meanwhile.
- R12: Code `000001` changes nothing. Code `000000` halts: `halted` rises and `syl_ready` stays low until reset.
- R13: A syllable that needs more entries than the stack holds, or that pushes onto a full stack (DEPTH entries), leaves the stack unchanged, sets `fault` sticky and halts.
- R14: Codes `001111` and `000101` set `unsup` sticky, leave the stack unchanged, and execution continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| syl_valid | input | 1 | Syllable offered |
| syl_ready | output | 1 | Unit can accept a syllable |
| syl_wide | input | 1 | Push `syl_word` instead of decoding `syl_code` |
| syl_code | input | 6 | Syllable encoding |
| syl_word | input | W | Full-width immediate |
| mem_req | output | 1 | Memory request held until acknowledged |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | W | Memory address |
| mem_wdata | output | W | Store data |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | W | Load data, valid with `mem_ack` |
| redir_valid | output | 1 | One-cycle PC redirect |
| redir_pc | output | W | Redirect target |
| psw_flags | output | 2 | Bit 1 negative, bit 0 zero |
| depth | output | $clog2(DEPTH+1) | Entries on the stack |
| halted | output | 1 | Unit is halted |
| fault | output | 1 | Sticky stack underflow/overflow |
| unsup | output | 1 | Sticky unsupported-operation flag |

## Verification
The bench builds the unit with DEPTH = 10 and W = 32. Ten entries hold nine operands plus a copy, so every copy distance 0 to 7 and every overwrite distance 0 to 7 can be swept against a filled stack. A full stack is also reached in a handful of pushes, so overflow is cheap to hit. The sweeps cover all 32 short immediates, shift amounts from -36 to +36, and eight operand pairs through each logic and add operation. Results are popped out through the jump redirect and compared with values the bench computes itself.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [4:0] {
        OP_IMM, OP_LDSP, OP_STSP, OP_AND, OP_OR, OP_NOT, OP_XOR, OP_ADD,
        OP_SWAP, OP_JMP, OP_SHIFT, OP_TEST, OP_BRZ, OP_LOAD, OP_STORE,
        OP_NOP, OP_HALT, OP_UNSUP
    } op_e;

    typedef enum logic [1:0] {
        ST_RUN, ST_MEMWAIT, ST_HALT
    } state_e;

    typedef enum logic [2:0] {
        ALU_AND, ALU_OR, ALU_XOR, ALU_ADD, ALU_NOT, ALU_SHIFT
    } alu_e;

    function automatic op_e decode_syl(input logic [5:0] c);
        op_e r;
        if (c[5])                  r = OP_IMM;
        else if (c[4:3] == 2'b11)  r = OP_LDSP;
        else if (c[4:3] == 2'b10)  r = OP_STSP;
        else if (c[4:3] == 2'b01) begin
            case (c[2:0])
                3'd0:    r = OP_AND;
                3'd1:    r = OP_OR;
                3'd2:    r = OP_NOT;
                3'd3:    r = OP_XOR;
                3'd4:    r = OP_ADD;
                3'd5:    r = OP_SWAP;
                3'd6:    r = OP_JMP;
                default: r = OP_UNSUP;
            endcase
        end else begin
            case (c[2:0])
                3'd0:    r = OP_HALT;
                3'd1:    r = OP_NOP;
                3'd2:    r = OP_LOAD;
                3'd3:    r = OP_STORE;
                3'd4:    r = OP_SHIFT;
                3'd5:    r = OP_UNSUP;
                3'd6:    r = OP_TEST;
                default: r = OP_BRZ;
            endcase
        end
        return r;
    endfunction

    // Entries a syllable must find on the stack before it may run.
    function automatic int need_of(input op_e op, input logic [2:0] x);
        case (op)
            OP_LDSP:                              return int'(x) + 1;
            OP_STSP:                              return int'(x) + 2;
            OP_NOT, OP_JMP, OP_TEST, OP_LOAD:     return 1;
            OP_AND, OP_OR, OP_XOR, OP_ADD, OP_SWAP,
            OP_SHIFT, OP_BRZ, OP_STORE:           return 2;
            default:                              return 0;
        endcase
    endfunction

endpackage

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_e         op,
    input  logic [W-1:0] tos,
    input  logic [W-1:0] nos,
    output logic [W-1:0] res
);
    localparam int SW = $clog2(W);

    logic         neg;
    logic [W-1:0] mag;
    logic         too_far;
    logic [W-1:0] shifted;

    always_comb begin
        neg     = tos[W-1];
        mag     = neg ? (~tos + W'(1)) : tos;
        too_far = |mag[W-1:SW];
        if (too_far)  shifted = '0;
        else if (neg) shifted = nos >> mag[SW-1:0];
        else          shifted = nos << mag[SW-1:0];
    end

    always_comb begin
        case (op)
            ALU_AND:   res = tos & nos;
            ALU_OR:    res = tos | nos;
            ALU_XOR:   res = tos ^ nos;
            ALU_ADD:   res = tos + nos;
            ALU_NOT:   res = ~tos;
            ALU_SHIFT: res = shifted;
            default:   res = '0;
        endcase
    end

endmodule

// File: rtl/stk_regfile.sv
module stk_regfile #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_a,
    input  logic [$clog2(DEPTH)-1:0]  idx_a,
    input  logic [W-1:0]              din_a,
    input  logic                      we_b,
    input  logic [$clog2(DEPTH)-1:0]  idx_b,
    input  logic [W-1:0]              din_b,
    input  logic [$clog2(DEPTH)-1:0]  rd0_idx,
    input  logic [$clog2(DEPTH)-1:0]  rd1_idx,
    input  logic [$clog2(DEPTH)-1:0]  rd2_idx,
    output logic [W-1:0]              rd0,
    output logic [W-1:0]              rd1,
    output logic [W-1:0]              rd2
);
    localparam int IW      = $clog2(DEPTH);
    localparam int ENTRIES = 1 << IW;

    logic [W-1:0] ent [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)                           ent[g] <= '0;
            else if (we_a && idx_a == IW'(g))     ent[g] <= din_a;
            else if (we_b && idx_b == IW'(g))     ent[g] <= din_b;
        end
    end

    assign rd0 = ent[rd0_idx];
    assign rd1 = ent[rd1_idx];
    assign rd2 = ent[rd2_idx];

    AST_SWAP_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (we_a && we_b) |-> (idx_a != idx_b)); // R6

endmodule

// File: rtl/stk_syl_exec.sv
module stk_syl_exec
    import stk_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int SPW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           syl_valid,
    output logic           syl_ready,
    input  logic           syl_wide,
    input  logic [5:0]     syl_code,
    input  logic [W-1:0]   syl_word,
    output logic           mem_req,
    output logic           mem_we,
    output logic [W-1:0]   mem_addr,
    output logic [W-1:0]   mem_wdata,
    input  logic           mem_ack,
    input  logic [W-1:0]   mem_rdata,
    output logic           redir_valid,
    output logic [W-1:0]   redir_pc,
    output logic [1:0]     psw_flags,
    output logic [SPW-1:0] depth,
    output logic           halted,
    output logic           fault,
    output logic           unsup
);
    state_e         state_q, state_d;
    logic [SPW-1:0] sp_q, sp_d;

    op_e            op;
    logic [2:0]     xoff;
    logic [W-1:0]   imm_val;
    int             need;
    logic           grow, bad, fire, mem_done;
    alu_e           alu_op;
    logic [W-1:0]   alu_res, tos, nos, rel;
    logic [IW-1:0]  top_idx, nos_idx, rel_idx, push_idx, stsp_idx;

    logic           wa_en, wb_en;
    logic [IW-1:0]  wa_idx, wb_idx;
    logic [W-1:0]   wa_dat, wb_dat;

    // ---------------- decode and stack bounds ----------------
    always_comb begin
        op       = syl_wide ? OP_IMM : decode_syl(syl_code);
        xoff     = syl_code[2:0];
        imm_val  = syl_wide ? syl_word : W'(syl_code[4:0]);
        need     = need_of(op, xoff);
        grow     = (op == OP_IMM) || (op == OP_LDSP);
        bad      = (int'(sp_q) < need) || (grow && int'(sp_q) == DEPTH);
        fire     = (state_q == ST_RUN) && syl_valid;
        mem_done = (state_q == ST_MEMWAIT) && mem_ack;
        top_idx  = IW'(sp_q - SPW'(1));
        nos_idx  = IW'(sp_q - SPW'(2));
        rel_idx  = IW'(sp_q - SPW'(xoff) - SPW'(1));
        stsp_idx = IW'(sp_q - SPW'(xoff) - SPW'(2));
        push_idx = IW'(sp_q);
    end

    always_comb begin
        case (op)
            OP_AND:   alu_op = ALU_AND;
            OP_OR:    alu_op = ALU_OR;
            OP_XOR:   alu_op = ALU_XOR;
            OP_NOT:   alu_op = ALU_NOT;
            OP_SHIFT: alu_op = ALU_SHIFT;
            default:  alu_op = ALU_ADD;
        endcase
    end

    stk_alu #(.W(W)) alu_i (
        .op (alu_op),
        .tos(tos),
        .nos(nos),
        .res(alu_res)
    );

    stk_regfile #(.W(W), .DEPTH(DEPTH)) rf_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_a   (wa_en),
        .idx_a  (wa_idx),
        .din_a  (wa_dat),
        .we_b   (wb_en),
        .idx_b  (wb_idx),
        .din_b  (wb_dat),
        .rd0_idx(top_idx),
        .rd1_idx(nos_idx),
        .rd2_idx(rel_idx),
        .rd0    (tos),
        .rd1    (nos),
        .rd2    (rel)
    );

    // ---------------- stack write and pointer control ----------------
    always_comb begin
        wa_en  = 1'b0;
        wa_idx = top_idx;
        wa_dat = alu_res;
        wb_en  = 1'b0;
        wb_idx = nos_idx;
        wb_dat = tos;
        sp_d   = sp_q;
        if (mem_done) begin
            if (!mem_we) begin
                wa_en  = 1'b1;
                wa_dat = mem_rdata;
            end else begin
                sp_d = sp_q - SPW'(2);
            end
        end else if (fire && !bad) begin
            case (op)
                OP_IMM: begin
                    wa_en = 1'b1; wa_idx = push_idx; wa_dat = imm_val;
                    sp_d  = sp_q + SPW'(1);
                end
                OP_LDSP: begin
                    wa_en = 1'b1; wa_idx = push_idx; wa_dat = rel;
                    sp_d  = sp_q + SPW'(1);
                end
                OP_STSP: begin
                    wa_en = 1'b1; wa_idx = stsp_idx; wa_dat = tos;
                    sp_d  = sp_q - SPW'(1);
                end
                OP_AND, OP_OR, OP_XOR, OP_ADD, OP_SHIFT: begin
                    wa_en = 1'b1; wa_idx = nos_idx;
                    sp_d  = sp_q - SPW'(1);
                end
                OP_NOT:  wa_en = 1'b1;
                OP_SWAP: begin
                    wa_en = 1'b1; wa_dat = nos;
                    wb_en = 1'b1;
                end
                OP_JMP, OP_TEST: sp_d = sp_q - SPW'(1);
                OP_BRZ:          sp_d = sp_q - SPW'(2);
                default: ;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (fire) begin
                    if (bad || op == OP_HALT)                  state_d = ST_HALT;
                    else if (op == OP_LOAD || op == OP_STORE)  state_d = ST_MEMWAIT;
                end
            end
            ST_MEMWAIT: if (mem_ack) state_d = ST_RUN;
            ST_HALT:    state_d = ST_HALT;
            default:    state_d = ST_HALT;
        endcase
    end

    // ---------------- state-decoded outputs ----------------
    always_comb begin
        syl_ready = (state_q == ST_RUN);
        mem_req   = (state_q == ST_MEMWAIT);
        halted    = (state_q == ST_HALT);
        depth     = sp_q;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q        <= '0;
            psw_flags   <= '0;
            redir_valid <= 1'b0;
            redir_pc    <= '0;
            mem_we      <= 1'b0;
            mem_addr    <= '0;
            mem_wdata   <= '0;
            fault       <= 1'b0;
            unsup       <= 1'b0;
        end else begin
            sp_q        <= sp_d;
            redir_valid <= fire && !bad &&
                           (op == OP_JMP || (op == OP_BRZ && nos == '0));
            if (fire && !bad && (op == OP_JMP || op == OP_BRZ))
                redir_pc <= tos;
            if (fire && !bad && op == OP_TEST)
                psw_flags <= {tos[W-1], (tos == '0)};
            if (fire && !bad && (op == OP_LOAD || op == OP_STORE)) begin
                mem_we    <= (op == OP_STORE);
                mem_addr  <= tos;
                mem_wdata <= nos;
            end
            if (fire && bad)                fault <= 1'b1;
            if (fire && op == OP_UNSUP)     unsup <= 1'b1;
        end
    end

    // ---------------- assertions ----------------
    AST_FAULT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> halted); // R13
    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sp_q) <= DEPTH); // R13
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && !syl_ready); // R12
    AST_REQ_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11
    AST_NO_ACCEPT_IN_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !syl_ready); // R11
    AST_UNSUP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unsup |=> unsup); // R14
    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !bad && op == OP_IMM) |=> (sp_q == $past(sp_q) + SPW'(1))); // R2

endmodule

// File: tb/stk_syl_exec_tb_top.sv
module stk_syl_exec_tb_top;
    localparam int W     = 32;
    localparam int DEPTH = 10;
    localparam int SPW   = $clog2(DEPTH + 1);

    localparam logic [5:0] C_AND = 6'b001000, C_OR = 6'b001001, C_NOT = 6'b001010,
                           C_XOR = 6'b001011, C_ADD = 6'b001100, C_SWAP = 6'b001101,
                           C_JMP = 6'b001110, C_CTX = 6'b001111, C_SHIFT = 6'b000100,
                           C_CAS = 6'b000101, C_TEST = 6'b000110, C_BRZ = 6'b000111,
                           C_LOAD = 6'b000010, C_STORE = 6'b000011, C_NOP = 6'b000001,
                           C_HALT = 6'b000000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           syl_valid = 1'b0, syl_wide = 1'b0;
    logic [5:0]     syl_code = '0;
    logic [W-1:0]   syl_word = '0;
    logic           syl_ready, mem_req, mem_we, redir_valid, halted, fault, unsup;
    logic [W-1:0]   mem_addr, mem_wdata, redir_pc;
    logic           mem_ack = 1'b0;
    logic [W-1:0]   mem_rdata = '0;
    logic [1:0]     psw_flags;
    logic [SPW-1:0] depth;

    int n_chk = 0, n_err = 0;
    logic [W-1:0] bmem [16];

    always #4 clk = ~clk;

    stk_syl_exec #(.W(W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .syl_valid(syl_valid), .syl_ready(syl_ready),
        .syl_wide(syl_wide), .syl_code(syl_code), .syl_word(syl_word),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .redir_valid(redir_valid),
        .redir_pc(redir_pc), .psw_flags(psw_flags), .depth(depth), .halted(halted),
        .fault(fault), .unsup(unsup)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // memory responder: acknowledges on the second cycle of a request
    initial begin
        int wait_cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_req) begin
                if (syl_ready) begin
                    n_chk++; n_err++;
                    $display("FAIL R11 ready during request actual=1 expected=0");
                end
                if (wait_cnt == 1) begin
                    mem_ack = 1'b1;
                    if (mem_we) bmem[mem_addr[5:2]] = mem_wdata;
                    else        mem_rdata = bmem[mem_addr[5:2]];
                    wait_cnt = 0;
                end else begin
                    mem_ack = 1'b0;
                    wait_cnt++;
                end
            end else begin
                mem_ack = 1'b0;
                wait_cnt = 0;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic wide, input logic [5:0] code, input logic [W-1:0] word);
        @(negedge clk);
        syl_valid = 1'b1; syl_wide = wide; syl_code = code; syl_word = word;
        @(posedge clk);
        @(negedge clk);
        syl_valid = 1'b0; syl_wide = 1'b0;
        while (!syl_ready && !halted) @(negedge clk);
    endtask

    task automatic push(input logic [W-1:0] v);
        send(1'b1, 6'b000000, v);
    endtask

    task automatic pop_chk(input string tag, input logic [W-1:0] exp);
        send(1'b0, C_JMP, '0);
        chk({tag, " redirect"}, W'(redir_valid), W'(1));
        chk(tag, redir_pc, exp);
    endtask

    function automatic logic [W-1:0] shexp(input logic [W-1:0] v, input int amt);
        if (amt >= 0) return (amt >= 32) ? '0 : (v << amt);
        return (-amt >= 32) ? '0 : (v >> (-amt));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [W-1:0] v [9];
        logic [W-1:0] m [8];
        for (int i = 0; i < 16; i++) bmem[i] = 32'hA5000000 + W'(i);
        do_reset();

        // R1: reset state
        chk("R1 depth", W'(depth), 0);
        chk("R1 flags", W'(psw_flags), 0);
        chk("R1 ready", W'(syl_ready), 1);
        chk("R1 halt/fault/unsup", W'({halted, fault, unsup}), 0);
        chk("R1 mem_req/redirect", W'({mem_req, redir_valid}), 0);

        // R2: all short immediates, then wide pushes with depth growth
        for (int i = 0; i < 32; i++) begin
            send(1'b0, {1'b1, 5'(i)}, 32'hFFFFFFFF);
            chk("R2 short depth", W'(depth), 1);
            pop_chk("R2 short imm", W'(i));
        end
        for (int i = 0; i < DEPTH; i++) begin
            push(32'hDEAD0000 ^ W'(i * 77));
            chk("R2 wide depth", W'(depth), W'(i + 1));
        end
        for (int i = DEPTH - 1; i >= 0; i--) pop_chk("R2 wide value", 32'hDEAD0000 ^ W'(i * 77));
        // R8: redirect is a single-cycle pulse
        @(negedge clk);
        chk("R8 pulse ends", W'(redir_valid), 0);

        // R5: logic and add sweep
        for (int i = 0; i < 8; i++) begin
            logic [W-1:0] a, b;
            a = 32'h9E3779B9 * W'(i + 1);
            b = 32'h7F4A7C15 ^ W'(i << 7);
            push(a); push(b); send(1'b0, C_AND, '0); pop_chk("R5 AND", a & b);
            push(a); push(b); send(1'b0, C_OR,  '0); pop_chk("R5 OR",  a | b);
            push(a); push(b); send(1'b0, C_XOR, '0); pop_chk("R5 XOR", a ^ b);
            push(a); push(b); send(1'b0, C_ADD, '0);
            chk("R5 ADD depth", W'(depth), 1);
            pop_chk("R5 ADD", a + b);
            push(a); send(1'b0, C_NOT, '0); pop_chk("R5 NOT", ~a);
        end

        // R6: exchange
        push(32'h11111111); push(32'h22222222);
        send(1'b0, C_SWAP, '0);
        pop_chk("R6 top after swap", 32'h11111111);
        pop_chk("R6 next after swap", 32'h22222222);

        // R7: shift amount sweep
        for (int s = -36; s <= 36; s++) begin
            push(32'hC3A50F81); push(W'(s));
            send(1'b0, C_SHIFT, '0);
            pop_chk("R7 shift", shexp(32'hC3A50F81, s));
        end
        push(32'hFFFFFFFF); push(32'h80000000);
        send(1'b0, C_SHIFT, '0);
        pop_chk("R7 most negative amount", 0);

        // R3: copy at every distance
        for (int k = 0; k < 9; k++) v[k] = 32'h01010101 * W'(k + 3) + 32'h5;
        for (int k = 0; k < 9; k++) push(v[k]);
        for (int x = 0; x < 8; x++) begin
            send(1'b0, {3'b011, 3'(x)}, '0);
            chk("R3 depth", W'(depth), 10);
            pop_chk("R3 copy", v[8 - x]);
        end

        // R4: overwrite at every distance
        for (int x = 0; x < 8; x++) begin
            do_reset();
            for (int k = 0; k < 9; k++) push(v[k]);
            for (int k = 0; k < 8; k++) m[k] = v[k];
            m[7 - x] = v[8];
            send(1'b0, {3'b010, 3'(x)}, '0);
            chk("R4 depth", W'(depth), 8);
            for (int k = 7; k >= 0; k--) pop_chk("R4 entry", m[k]);
        end

        // R9: branch on zero
        push(0); push(32'h00000400);
        send(1'b0, C_BRZ, '0);
        chk("R9 taken", W'(redir_valid), 1);
        chk("R9 target", redir_pc, 32'h00000400);
        chk("R9 depth taken", W'(depth), 0);
        push(5); push(32'h00000800);
        send(1'b0, C_BRZ, '0);
        chk("R9 not taken", W'(redir_valid), 0);
        chk("R9 depth not taken", W'(depth), 0);
        push(32'h80000000); push(32'h00000C00);
        send(1'b0, C_BRZ, '0);
        chk("R9 sign-bit test word", W'(redir_valid), 0);

        // R10: status flags
        push(0); send(1'b0, C_TEST, '0);
        chk("R10 zero", W'(psw_flags), 2'b01);
        chk("R10 depth", W'(depth), 0);
        push(32'h80000000); send(1'b0, C_TEST, '0);
        chk("R10 negative", W'(psw_flags), 2'b10);
        push(32'h7FFFFFFF); send(1'b0, C_TEST, '0);
        chk("R10 positive", W'(psw_flags), 2'b00);
        push(32'hFFFFFFFF); send(1'b0, C_TEST, '0);
        push(0); send(1'b0, C_NOT, '0); send(1'b0, C_NOP, '0);
        chk("R10 kept by other ops", W'(psw_flags), 2'b10);
        pop_chk("R10 stack intact", 32'hFFFFFFFF);

        // R11: store then load
        push(32'hBEEF1234); push(32'h00000014);
        send(1'b0, C_STORE, '0);
        chk("R11 store data", bmem[5], 32'hBEEF1234);
        chk("R11 store depth", W'(depth), 0);
        push(32'h00000014); send(1'b0, C_LOAD, '0);
        chk("R11 load depth", W'(depth), 1);
        pop_chk("R11 load data", 32'hBEEF1234);
        push(32'h00000020); send(1'b0, C_LOAD, '0);
        pop_chk("R11 load other", 32'hA5000008);

        // R14: unsupported encodings
        push(7);
        send(1'b0, C_CTX, '0);
        chk("R14 flag", W'(unsup), 1);
        chk("R14 running", W'({halted, syl_ready}), 2'b01);
        send(1'b0, C_CAS, '0);
        chk("R14 depth", W'(depth), 1);
        pop_chk("R14 stack intact", 7);

        // R12: no-op and halt
        push(9); send(1'b0, C_NOP, '0);
        chk("R12 nop depth", W'(depth), 1);
        pop_chk("R12 nop value", 9);
        send(1'b0, C_HALT, '0);
        repeat (3) @(negedge clk);
        chk("R12 halted", W'({halted, syl_ready, fault}), 3'b100);

        // R13: underflow, copy too deep, overflow
        do_reset();
        send(1'b0, C_JMP, '0);
        chk("R13 underflow", W'({fault, halted}), 2'b11);
        chk("R13 underflow no redirect", W'(redir_valid), 0);
        do_reset();
        push(4);
        send(1'b0, {3'b011, 3'd1}, '0);
        chk("R13 copy too deep", W'({fault, halted}), 2'b11);
        chk("R13 depth kept", W'(depth), 1);
        do_reset();
        for (int i = 0; i < DEPTH; i++) push(W'(i));
        chk("R13 no fault at full", W'(fault), 0);
        push(32'h12345678);
        chk("R13 overflow", W'({fault, halted}), 2'b11);
        chk("R13 depth at full", W'(depth), W'(DEPTH));

        summary();
        $finish;
    end

endmodule